// File: doc/BRIEF.md
# Flag-Setting Add/Subtract Unit

This block is a 32-bit integer adder/subtractor that produces a result together with a fresh set of condition flags: negative, zero, carry and overflow. It supports four operations: plain add, add with the incoming carry, plain subtract, and subtract with the incoming carry. A 2-bit operation code selects the operation. The current carry flag enters as an input. The block does not store flags. The surrounding pipeline keeps them and feeds the carry back in.

After a subtraction the carry flag means that no borrow took place. For the borrowing subtract, a clear incoming carry takes one extra unit from the difference. An output stage chosen by a parameter either registers the result and flags behind a valid strobe, adding one cycle of latency, or passes them straight through.

Top module: `flag_addsub`

## Requirements
- R1: With op_sel = 2'b00 (add), result is opnd_a + opnd_b modulo 2^32, and flag_c is set exactly when that result is unsigned-less than opnd_a. carry_in has no effect.
- R2: With op_sel = 2'b01 (add with carry), a set carry_in gives result opnd_a + opnd_b + 1, with flag_c set exactly when result <= opnd_a. A clear carry_in gives the same outputs as R1.
- R3: With op_sel = 2'b10 (subtract), result is opnd_a - opnd_b modulo 2^32, and flag_c is set exactly when opnd_a >= opnd_b (unsigned). carry_in has no effect.
- R4: With op_sel = 2'b11 (subtract with carry), a clear carry_in gives result opnd_a - opnd_b - 1, with flag_c set exactly when opnd_a > opnd_b. A set carry_in gives the same outputs as R3.
- R5: flag_v is bit 31 of (~(opnd_a ^ opnd_b)) & (opnd_a ^ result) for the add forms. For the subtract forms it is bit 31 of (opnd_a ^ opnd_b) & (opnd_a ^ result).
- R6: flag_n equals bit 31 of result, and flag_z is set exactly when result is all zeros.
- R7: With OUT_REG = 1, result and the flags for an operand set presented with in_valid high appear after the next rising clk edge, and out_valid is then high. With OUT_REG = 0 they appear in the same cycle, and out_valid equals in_valid.
- R8: With OUT_REG = 1, a low rst_n clears out_valid, result and all four flags.
- R9: With OUT_REG = 1, an edge with in_valid low leaves result and the flags unchanged and drives out_valid low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| in_valid | input | 1 | Operands and operation code are valid |
| op_sel | input | 2 | 00 add, 01 add with carry, 10 subtract, 11 subtract with carry |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result and flags are valid |
| result | output | WIDTH | Sum or difference |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag (no-borrow after subtract) |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The bench builds two copies at WIDTH = 32: one with OUT_REG = 1 and one with OUT_REG = 0. Both are driven with the same stimulus, so the registered path and the pass-through path are checked against each other and against a reference model in the same cycle. The registered copy exposes the latency, reset and hold behaviour. The pass-through copy shows the raw flag logic with no clock involved. The stimulus reaches the 32-bit carry and overflow boundaries with operands 0, 0xFFFFFFFF, 0x7FFFFFFF and 0x80000000.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_ADC = 2'b01,
        OP_SUB = 2'b10,
        OP_SBC = 2'b11
    } addsub_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } cond_flags_t;

endpackage

// File: rtl/addsub_core.sv
module addsub_core
    import addsub_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  addsub_op_e       op,
    input  logic             carry_in,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum,
    output logic [WIDTH-1:0] b_eff,
    output logic             cout
);
    localparam int SUMW = WIDTH + 1;

    logic             is_sub;
    logic             cin_eff;
    logic [SUMW-1:0]  wide_sum;

    always_comb begin
        is_sub = (op == OP_SUB) || (op == OP_SBC);
        unique case (op)
            OP_ADD:  cin_eff = 1'b0;
            OP_ADC:  cin_eff = carry_in;
            OP_SUB:  cin_eff = 1'b1;
            OP_SBC:  cin_eff = carry_in;
            default: cin_eff = 1'b0;
        endcase
        b_eff    = is_sub ? ~b : b;
        wide_sum = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_eff};
        sum      = wide_sum[WIDTH-1:0];
        cout     = wide_sum[SUMW-1];
    end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
    import addsub_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b_eff,
    input  logic [WIDTH-1:0] sum,
    input  logic             cout,
    output cond_flags_t      flags
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        flags.n = sum[MSB];
        flags.z = (sum == '0);
        flags.c = cout;
        flags.v = ~(a[MSB] ^ b_eff[MSB]) & (a[MSB] ^ sum[MSB]);
    end
endmodule

// File: rtl/addsub_outstage.sv
module addsub_outstage
    import addsub_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] sum_in,
    input  cond_flags_t      flags_in,
    output logic             out_valid,
    output logic [WIDTH-1:0] sum_out,
    output cond_flags_t      flags_out
);
    generate
        if (OUT_REG) begin : g_reg
            logic             vld_q;
            logic [WIDTH-1:0] sum_q;
            cond_flags_t      flg_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q <= 1'b0;
                    sum_q <= '0;
                    flg_q <= '0;
                end else begin
                    vld_q <= in_valid;
                    if (in_valid) begin
                        sum_q <= sum_in;
                        flg_q <= flags_in;
                    end
                end
            end

            always_comb begin
                out_valid = vld_q;
                sum_out   = sum_q;
                flags_out = flg_q;
            end
        end else begin : g_pass
            always_comb begin
                out_valid = in_valid;
                sum_out   = sum_in;
                flags_out = flags_in;
            end
        end
    endgenerate
endmodule

// File: rtl/flag_addsub.sv
module flag_addsub
    import addsub_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       op_sel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             carry_in,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_v
);
    addsub_op_e       op;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] b_eff;
    logic             cout;
    cond_flags_t      flags_raw;
    cond_flags_t      flags_out;

    assign op = addsub_op_e'(op_sel);

    addsub_core #(.WIDTH(WIDTH)) u_core (
        .op       (op),
        .carry_in (carry_in),
        .a        (opnd_a),
        .b        (opnd_b),
        .sum      (sum),
        .b_eff    (b_eff),
        .cout     (cout)
    );

    addsub_flags #(.WIDTH(WIDTH)) u_flags (
        .a     (opnd_a),
        .b_eff (b_eff),
        .sum   (sum),
        .cout  (cout),
        .flags (flags_raw)
    );

    addsub_outstage #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .sum_in    (sum),
        .flags_in  (flags_raw),
        .out_valid (out_valid),
        .sum_out   (result),
        .flags_out (flags_out)
    );

    assign flag_n = flags_out.n;
    assign flag_z = flags_out.z;
    assign flag_c = flags_out.c;
    assign flag_v = flags_out.v;
endmodule

// File: rtl/flag_addsub_chk.sv
module flag_addsub_chk #(
    parameter int WIDTH   = 32,
    parameter bit OUT_REG = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       op_sel,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic             carry_in,
    input logic             out_valid,
    input logic [WIDTH-1:0] result,
    input logic             flag_n,
    input logic             flag_z,
    input logic             flag_c,
    input logic             flag_v
);
    assert_neg_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_n == result[WIDTH-1]));

    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_z == (result == '0)));

    generate
        if (OUT_REG) begin : g_reg_chk
            assert_valid_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);

            assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> (!out_valid && $stable(result) && $stable(flag_c) && $stable(flag_v)));

            assert_add_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op_sel == 2'b00) |=> (flag_c == (result < $past(opnd_a))));

            assert_sub_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op_sel == 2'b10) |=> (flag_c == ($past(opnd_a) >= $past(opnd_b))));
        end else begin : g_pass_chk
            assert_valid_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid == in_valid);

            assert_add_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op_sel == 2'b00) |-> (flag_c == (result < opnd_a)));

            assert_sub_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op_sel == 2'b10) |-> (flag_c == (opnd_a >= opnd_b)));

            assert_no_carry_effect_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op_sel == 2'b00) |-> (result == opnd_a + opnd_b));
        end
    endgenerate
endmodule

bind flag_addsub flag_addsub_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/flag_addsub_test.sv
module flag_addsub_test;
    localparam int W   = 32;
    localparam int VW  = 2 + 1 + W + W + W + 4;
    localparam int NV  = 12;
    localparam int NRND = 400;

    // Vector layout: op, carry_in, a, b, expected result, expected {n,z,c,v}
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'b00, 1'b1, 32'h00000000, 32'h00000000, 32'h00000000, 4'b0100},
        {2'b00, 1'b0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 4'b0110},
        {2'b00, 1'b0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 4'b1001},
        {2'b01, 1'b1, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 4'b0110},
        {2'b01, 1'b0, 32'h00000005, 32'h00000003, 32'h00000008, 4'b0000},
        {2'b10, 1'b0, 32'h00000005, 32'h00000005, 32'h00000000, 4'b0110},
        {2'b10, 1'b1, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 4'b1000},
        {2'b10, 1'b0, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 4'b0011},
        {2'b11, 1'b0, 32'h00000005, 32'h00000005, 32'hFFFFFFFF, 4'b1000},
        {2'b11, 1'b1, 32'h00000005, 32'h00000005, 32'h00000000, 4'b0110},
        {2'b11, 1'b0, 32'h00000006, 32'h00000005, 32'h00000000, 4'b0110},
        {2'b00, 1'b0, 32'h80000000, 32'h80000000, 32'h00000000, 4'b0111}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   op_sel = 2'b00;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic         carry_in = 1'b0;

    logic         vld_r, vld_c;
    logic [W-1:0] res_r, res_c;
    logic         n_r, z_r, c_r, v_r;
    logic         n_c, z_c, c_c, v_c;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    flag_addsub #(.WIDTH(W), .OUT_REG(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
        .out_valid(vld_r), .result(res_r),
        .flag_n(n_r), .flag_z(z_r), .flag_c(c_r), .flag_v(v_r)
    );

    flag_addsub #(.WIDTH(W), .OUT_REG(1'b0)) uut_comb (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
        .out_valid(vld_c), .result(res_c),
        .flag_n(n_c), .flag_z(z_c), .flag_c(c_c), .flag_v(v_c)
    );

    task automatic check(input string req, input logic [W+3:0] act, input logic [W+3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference built from the requirement wording (R1..R6)
    function automatic logic [W+3:0] model(input logic [1:0] op, input logic cin,
                                           input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] r;
        logic c, v;
        case (op)
            2'b00: begin r = a + b; c = (r < a); end
            2'b01: if (cin) begin r = a + b + 1; c = (r <= a); end
                   else     begin r = a + b;     c = (r < a);  end
            2'b10: begin r = a - b; c = (a >= b); end
            default: if (!cin) begin r = a - b - 1; c = (a > b);  end
                     else      begin r = a - b;     c = (a >= b); end
        endcase
        if (op[1]) v = ((a ^ b) & (a ^ r)) >> (W-1);
        else       v = ((~(a ^ b)) & (a ^ r)) >> (W-1);
        return {r, r[W-1], (r == '0), c, v};
    endfunction

    function automatic logic [W-1:0] pick();
        case ($urandom_range(0, 7))
            0: return 32'h00000000;
            1: return 32'hFFFFFFFF;
            2: return 32'h80000000;
            3: return 32'h7FFFFFFF;
            default: return $urandom;
        endcase
    endfunction

    // Drive at a falling edge, check pass-through copy, then registered copy one edge later
    task automatic apply(input string req, input logic [1:0] op, input logic cin,
                         input logic [W-1:0] a, input logic [W-1:0] b, input logic [W+3:0] exp);
        @(negedge clk);
        in_valid = 1'b1; op_sel = op; carry_in = cin; opnd_a = a; opnd_b = b;
        #1;
        check({req, " pass-through R7"}, {res_c, n_c, z_c, c_c, v_c}, exp);
        @(negedge clk);
        check({req, " registered R7"}, {res_r, n_r, z_r, c_r, v_r}, exp);
        check("out_valid high R7", {{(W+3){1'b0}}, vld_r}, {{(W+3){1'b0}}, 1'b1});
    endtask

    initial begin
        #1_900_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R7: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [W+3:0] snap;
        // R8: reset state
        repeat (3) @(negedge clk);
        check("reset clears outputs R8", {res_r, n_r, z_r, c_r, v_r}, '0);
        check("reset clears out_valid R8", {{(W+3){1'b0}}, vld_r}, '0);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] e;
            e = VEC[i];
            apply($sformatf("vector %0d op %b R1 R2 R3 R4 R5 R6", i, e[VW-1 -: 2]),
                  e[VW-1 -: 2], e[VW-3], e[2*W+W+3 -: W], e[2*W+3 -: W], e[W+3:0]);
        end

        // Random and corner operands against the reference, every op and carry value
        for (int k = 0; k < NRND; k++) begin
            logic [1:0] op;
            logic cin;
            logic [W-1:0] a, b;
            op = 2'(k % 4); cin = 1'((k / 4) % 2);
            a = pick(); b = pick();
            apply($sformatf("random op %b cin %b R1 R2 R3 R4 R5 R6", op, cin), op, cin, a, b,
                  model(op, cin, a, b));
        end

        // R1 / R3: carry_in ignored by plain add and subtract
        apply("add ignores carry_in R1", 2'b00, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF,
              {32'hFFFFFFFE, 4'b1010});
        apply("sub ignores carry_in R3", 2'b10, 1'b0, 32'h00000003, 32'h00000001,
              {32'h00000002, 4'b0010});

        // R9: hold while in_valid low
        apply("load before hold R4", 2'b11, 1'b0, 32'h00000000, 32'h00000000,
              {32'hFFFFFFFF, 4'b1000});
        snap = {res_r, n_r, z_r, c_r, v_r};
        @(negedge clk);
        in_valid = 1'b0; op_sel = 2'b00; opnd_a = 32'h12345678; opnd_b = 32'h1;
        @(negedge clk);
        @(negedge clk);
        check("hold while idle R9", {res_r, n_r, z_r, c_r, v_r}, snap);
        check("out_valid low when idle R9", {{(W+3){1'b0}}, vld_r}, '0);
        check("pass-through valid follows R7", {{(W+3){1'b0}}, vld_c}, '0);

        // R8: reset after activity
        in_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check("reset after use R8", {res_r, n_r, z_r, c_r, v_r}, '0);
        check("reset out_valid R8", {{(W+3){1'b0}}, vld_r}, '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule